// File: doc/BRIEF.md
# Asynchronous Serial Frame Receiver

This block takes one asynchronous NRZ serial line and turns it into received data words. The line is first passed through a two-flop synchronizer. It is then examined once per receive-time tick (`rt_tick`), a one-clock enable pulse that the surrounding logic issues sixteen times per bit period. The block accepts a start bit only after the line has been high for a minimum number of ticks. It takes each bit as the majority of three samples near the bit centre, checks every stop bit, and reports the word together with its optional parity/control bit. When a stop bit is found low, it flags a framing error, and it separately marks a frame that held nothing but zeros as a break. A line that stays high for a whole frame length while no frame is in progress is reported as idle.

Two format inputs select the frame layout: `frame_long` chooses between 10-bit and 11-bit frames, and `fmt_sel` chooses the split into data, control and stop bits. Both inputs are captured when a start bit is accepted, so a change during a frame takes effect at the next frame. The received word and control bit stay on their outputs until the next frame completes or fails.

The controller has five states:
- WAIT looks for a qualified falling edge and moves to START.
- START returns to WAIT if its centre vote is high, which is a false start. Otherwise it moves to DATA.
- DATA moves after its last data bit to CTL, or to STOP if the format has no control bit.
- CTL always moves on to STOP.
- STOP returns to WAIT either on a low vote, which is an error, or after its last stop bit, which is a good frame.

Top module: `serial_frame_rx`

## Requirements
- R1: After reset, `data_out` and `ctl_bit` are zero and no strobe (`data_valid`, `frame_err`, `break_det`, `idle_det`) is asserted until the line provides cause.
- R2: A falling edge starts a frame only if the synchronized line was high on at least the 3 immediately preceding ticks while waiting. The tick carrying the low sample counts as RT1 of the start bit. A falling edge after only 2 high ticks is ignored.
- R3: If the start-bit centre vote is high, the receiver returns to waiting with no strobe. A later frame is then received normally.
- R4: Each bit value is the majority of the samples taken on RT8, RT9 and RT10 of that bit. A single deviating sample among those three, or any deviation on the other thirteen ticks of the bit, does not change the result.
- R5: Data bits arrive least significant bit first. For 7-bit data, `data_out[7]` is zero. When the format has no control bit, `ctl_bit` is zero.
- R6: With `frame_long`=0, `fmt_sel`=00 selects 8 data + 1 stop, 01 selects 7 data + control + 1 stop, and 10 or 11 selects 7 data + 2 stop.
- R7: With `frame_long`=1, `fmt_sel[0]`=0 selects 8 data + control + 1 stop and `fmt_sel[0]`=1 selects 7 data + control + 2 stop. `fmt_sel[1]` has no effect.
- R8: `data_valid` is a one-clock pulse following the RT10 tick of the last stop bit, which is tick 16·(frame_bits−1)+10 counted from RT1 of the start bit. It is raised only if every stop bit voted high.
- R9: A low vote on any stop bit, including the second of two, pulses `frame_err` for one clock instead of `data_valid`. It also loads the received bits into `data_out`.
- R10: `break_det` pulses together with `frame_err` when every data bit and the control bit (if present) voted zero. It stays low on framing errors with any one in the data.
- R11: `idle_det` pulses once when the waiting receiver has seen 16·frame_bits consecutive high ticks (160 for 10-bit, 176 for 11-bit). It does not pulse again while the line stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rt_tick | input | 1 | Receive-time enable, one clock wide, 16 per bit |
| line_in | input | 1 | Asynchronous serial line, idle high |
| frame_long | input | 1 | 0 selects 10-bit frames, 1 selects 11-bit frames |
| fmt_sel | input | 2 | Data/control/stop layout within the chosen frame length |
| data_out | output | 8 | Last received data word, LSB first on the line |
| ctl_bit | output | 1 | Last received parity/control bit (0 if absent) |
| data_valid | output | 1 | One-clock strobe for a frame with good stop bits |
| frame_err | output | 1 | One-clock strobe for a low stop-bit vote |
| break_det | output | 1 | One-clock strobe for an all-zero frame |
| idle_det | output | 1 | One-clock strobe after a frame length of high line |

## Verification
The receive path is driven with every layout of both frame lengths, each using a different data word. This separates data widths, control-bit placement and stop counts, and shows that the unused `fmt_sel` bit has no effect. The bench then applies several kinds of distorted line input, each aimed at one mechanism:
- Frames with one flipped sample at a rotating centre position and another outside the window show whether the three-sample vote is in place.
- A short low glitch, and falling edges after two or three high ticks, find the start qualification threshold and the false-start recovery.
- Low stop bits in one- and two-stop formats, and a fully low frame, separate a plain framing error from a break.
- Long high runs in both frame lengths locate the idle threshold and show that it fires only once.

// File: rtl/rx_pkg.sv
package rx_pkg;

    localparam int MAX_DATA = 8;
    localparam int IDX_W    = $clog2(MAX_DATA);
    localparam int CNT_W    = 4;

    typedef enum logic [2:0] {
        ST_WAIT,
        ST_START,
        ST_DATA,
        ST_CTL,
        ST_STOP
    } rx_state_t;

    typedef struct packed {
        logic [CNT_W-1:0] n_data;
        logic             has_ctl;
        logic [1:0]       n_stop;
        logic [CNT_W-1:0] n_total;
    } rx_fmt_t;

    // Map the frame length bit and layout selector to bit counts.
    function automatic rx_fmt_t fmt_decode(input logic long_f, input logic [1:0] sel);
        rx_fmt_t f;
        if (!long_f) begin
            unique case (sel)
                2'b00:   begin f.n_data = 4'd8; f.has_ctl = 1'b0; f.n_stop = 2'd1; end
                2'b01:   begin f.n_data = 4'd7; f.has_ctl = 1'b1; f.n_stop = 2'd1; end
                default: begin f.n_data = 4'd7; f.has_ctl = 1'b0; f.n_stop = 2'd2; end
            endcase
        end else if (!sel[0]) begin
            f.n_data = 4'd8; f.has_ctl = 1'b1; f.n_stop = 2'd1;
        end else begin
            f.n_data = 4'd7; f.has_ctl = 1'b1; f.n_stop = 2'd2;
        end
        f.n_total = 4'd1 + f.n_data + {3'b000, f.has_ctl} + {2'b00, f.n_stop};
        return f;
    endfunction

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic d_sync
);

    logic [STAGES-1:0] chain;

    // Chain resets to the idle (high) line level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '1;
        end else begin
            chain <= {chain[STAGES-2:0], d_async};
        end
    end

    assign d_sync = chain[STAGES-1];

endmodule

// File: rtl/rx_bit_sampler.sv
module rx_bit_sampler #(
    parameter int OSR = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rt_tick,
    input  logic line_s,
    input  logic restart,
    input  logic active,
    output logic bit_done,
    output logic bit_val
);

    localparam int RT_W = $clog2(OSR + 1);
    localparam int SA   = OSR / 2;
    localparam int SB   = SA + 1;
    localparam int SC   = SA + 2;

    logic [RT_W-1:0] rt_cnt;
    logic [RT_W-1:0] rt_next;
    logic            s_a;
    logic            s_b;

    always_comb begin
        if (restart || rt_cnt == RT_W'(OSR)) begin
            rt_next = RT_W'(1);
        end else begin
            rt_next = rt_cnt + RT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rt_cnt <= '0;
            s_a    <= 1'b1;
            s_b    <= 1'b1;
        end else if (rt_tick && (restart || active)) begin
            rt_cnt <= rt_next;
            if (rt_next == RT_W'(SA)) s_a <= line_s;
            if (rt_next == RT_W'(SB)) s_b <= line_s;
        end
    end

    // Vote is formed on the third centre sample, using the live line value.
    assign bit_done = rt_tick && active && (rt_next == RT_W'(SC));
    assign bit_val  = (s_a & s_b) | (s_a & line_s) | (s_b & line_s);

    // R4
    rt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (rt_cnt >= RT_W'(1) && rt_cnt <= RT_W'(OSR)));

endmodule

// File: rtl/rx_idle_watch.sv
module rx_idle_watch #(
    parameter int OSR      = 16,
    parameter int MIN_ONES = 3,
    parameter int FB_W     = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rt_tick,
    input  logic            line_s,
    input  logic            waiting,
    input  logic [FB_W-1:0] frame_bits,
    output logic            start_ok,
    output logic            idle_pulse
);

    localparam int RUN_W = $clog2(OSR * ((1 << FB_W) - 1) + 1);

    logic [RUN_W-1:0] run;
    logic [RUN_W-1:0] limit;

    assign limit = RUN_W'(int'(frame_bits) * OSR);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run        <= '0;
            idle_pulse <= 1'b0;
        end else begin
            idle_pulse <= 1'b0;
            if (!waiting) begin
                run <= '0;
            end else if (rt_tick) begin
                if (!line_s) begin
                    run <= '0;
                end else if (run < limit) begin
                    run <= run + RUN_W'(1);
                    if (run == limit - RUN_W'(1)) idle_pulse <= 1'b1;
                end
            end
        end
    end

    assign start_ok = waiting && rt_tick && !line_s && (run >= RUN_W'(MIN_ONES));

    // R11
    idle_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idle_pulse |=> !idle_pulse);

endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
    import rx_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_ok,
    input  logic                bit_done,
    input  logic                bit_val,
    input  logic [CNT_W-1:0]    cfg_data,
    input  logic                cfg_ctl,
    input  logic [1:0]          cfg_stop,
    output logic                waiting,
    output logic [MAX_DATA-1:0] data_out,
    output logic                ctl_bit,
    output logic                data_valid,
    output logic                frame_err,
    output logic                break_det
);

    rx_state_t           state;
    rx_state_t           nxt;
    logic [CNT_W-1:0]    n_data_q;
    logic                has_ctl_q;
    logic [1:0]          n_stop_q;
    logic [CNT_W-1:0]    bit_idx;
    logic [MAX_DATA-1:0] shreg;
    logic                ctl_q;
    logic                all_zero;
    logic                last_data;
    logic                last_stop;

    assign last_data = (bit_idx == n_data_q - CNT_W'(1));
    assign last_stop = (bit_idx == CNT_W'(n_stop_q) - CNT_W'(1));
    assign waiting   = (state == ST_WAIT);

    always_comb begin
        nxt = state;
        unique case (state)
            ST_WAIT:  if (start_ok) nxt = ST_START;
            ST_START: if (bit_done) nxt = bit_val ? ST_WAIT : ST_DATA;
            ST_DATA:  if (bit_done && last_data) nxt = has_ctl_q ? ST_CTL : ST_STOP;
            ST_CTL:   if (bit_done) nxt = ST_STOP;
            ST_STOP:  if (bit_done && (!bit_val || last_stop)) nxt = ST_WAIT;
            default:  nxt = ST_WAIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_WAIT;
        else        state <= nxt;
    end

    // Frame datapath: format capture, bit index, shift register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            n_data_q  <= CNT_W'(MAX_DATA);
            has_ctl_q <= 1'b0;
            n_stop_q  <= 2'd1;
            bit_idx   <= '0;
            shreg     <= '0;
            ctl_q     <= 1'b0;
            all_zero  <= 1'b1;
        end else begin
            unique case (state)
                ST_WAIT: begin
                    if (start_ok) begin
                        n_data_q  <= cfg_data;
                        has_ctl_q <= cfg_ctl;
                        n_stop_q  <= cfg_stop;
                        bit_idx   <= '0;
                        shreg     <= '0;
                        ctl_q     <= 1'b0;
                        all_zero  <= 1'b1;
                    end
                end
                ST_START: ;
                ST_DATA: begin
                    if (bit_done) begin
                        shreg[bit_idx[IDX_W-1:0]] <= bit_val;
                        all_zero <= all_zero & ~bit_val;
                        bit_idx  <= last_data ? '0 : bit_idx + CNT_W'(1);
                    end
                end
                ST_CTL: begin
                    if (bit_done) begin
                        ctl_q    <= bit_val;
                        all_zero <= all_zero & ~bit_val;
                    end
                end
                ST_STOP: if (bit_done) bit_idx <= bit_idx + CNT_W'(1);
                default: ;
            endcase
        end
    end

    // Registered outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_out   <= '0;
            ctl_bit    <= 1'b0;
            data_valid <= 1'b0;
            frame_err  <= 1'b0;
            break_det  <= 1'b0;
        end else begin
            data_valid <= 1'b0;
            frame_err  <= 1'b0;
            break_det  <= 1'b0;
            if (state == ST_STOP && bit_done) begin
                if (!bit_val) begin
                    frame_err <= 1'b1;
                    break_det <= all_zero;
                    data_out  <= shreg;
                    ctl_bit   <= ctl_q;
                end else if (last_stop) begin
                    data_valid <= 1'b1;
                    data_out   <= shreg;
                    ctl_bit    <= ctl_q;
                end
            end
        end
    end

    // R9
    no_valid_with_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(data_valid && frame_err));

    // R10
    break_needs_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        break_det |-> frame_err);

    // R8
    valid_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid |=> !data_valid);

    // R8
    valid_from_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid |-> $past(state == ST_STOP));

endmodule

// File: rtl/serial_frame_rx.sv
module serial_frame_rx
    import rx_pkg::*;
#(
    parameter int OSR         = 16,
    parameter int SYNC_STAGES = 2,
    parameter int MIN_ONES    = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rt_tick,
    input  logic                line_in,
    input  logic                frame_long,
    input  logic [1:0]          fmt_sel,
    output logic [MAX_DATA-1:0] data_out,
    output logic                ctl_bit,
    output logic                data_valid,
    output logic                frame_err,
    output logic                break_det,
    output logic                idle_det
);

    rx_fmt_t fmt;
    logic    line_s;
    logic    waiting;
    logic    start_ok;
    logic    bit_done;
    logic    bit_val;

    assign fmt = fmt_decode(frame_long, fmt_sel);

    rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (line_in),
        .d_sync  (line_s)
    );

    rx_idle_watch #(.OSR(OSR), .MIN_ONES(MIN_ONES), .FB_W(CNT_W)) u_idle (
        .clk        (clk),
        .rst_n      (rst_n),
        .rt_tick    (rt_tick),
        .line_s     (line_s),
        .waiting    (waiting),
        .frame_bits (fmt.n_total),
        .start_ok   (start_ok),
        .idle_pulse (idle_det)
    );

    rx_bit_sampler #(.OSR(OSR)) u_samp (
        .clk      (clk),
        .rst_n    (rst_n),
        .rt_tick  (rt_tick),
        .line_s   (line_s),
        .restart  (start_ok),
        .active   (!waiting),
        .bit_done (bit_done),
        .bit_val  (bit_val)
    );

    rx_frame_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_ok   (start_ok),
        .bit_done   (bit_done),
        .bit_val    (bit_val),
        .cfg_data   (fmt.n_data),
        .cfg_ctl    (fmt.has_ctl),
        .cfg_stop   (fmt.n_stop),
        .waiting    (waiting),
        .data_out   (data_out),
        .ctl_bit    (ctl_bit),
        .data_valid (data_valid),
        .frame_err  (frame_err),
        .break_det  (break_det)
    );

    // R2
    start_on_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(waiting) |-> !$past(line_s));

    // R11
    idle_while_waiting_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idle_det |-> $past(waiting));

endmodule

// File: tb/sim_serial_frame_rx.sv
module sim_serial_frame_rx;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rt_tick = 1'b0;
    logic       line_in = 1'b1;
    logic       frame_long = 1'b0;
    logic [1:0] fmt_sel = 2'b00;
    logic [7:0] data_out;
    logic       ctl_bit;
    logic       data_valid;
    logic       frame_err;
    logic       break_det;
    logic       idle_det;

    int n_checks = 0;
    int n_fail   = 0;

    int tick_count = 0;
    int n_valid = 0, n_ferr = 0, n_brk = 0, n_idle = 0;
    logic [7:0] lat_data = '0;
    logic       lat_ctl = 1'b0;
    int         lat_tick = 0;
    logic [1:0] div = '0;

    serial_frame_rx u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .rt_tick    (rt_tick),
        .line_in    (line_in),
        .frame_long (frame_long),
        .fmt_sel    (fmt_sel),
        .data_out   (data_out),
        .ctl_bit    (ctl_bit),
        .data_valid (data_valid),
        .frame_err  (frame_err),
        .break_det  (break_det),
        .idle_det   (idle_det)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) begin
        div     <= div + 2'd1;
        rt_tick <= (div == 2'd3);
    end

    always @(posedge clk) begin
        if (rt_tick) tick_count <= tick_count + 1;
        if (data_valid) begin
            n_valid  <= n_valid + 1;
            lat_data <= data_out;
            lat_ctl  <= ctl_bit;
            lat_tick <= tick_count;
        end
        if (frame_err) n_ferr <= n_ferr + 1;
        if (break_det) n_brk  <= n_brk + 1;
        if (idle_det)  n_idle <= n_idle + 1;
    end

    task automatic check_eq(input string tag, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        while (rt_tick !== 1'b1) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic hold(input logic v, input int n);
        line_in = v;
        repeat (n) tick();
    endtask

    task automatic do_reset(input logic fl, input logic [1:0] sel, input logic lvl);
        @(negedge clk);
        rst_n      = 1'b0;
        frame_long = fl;
        fmt_sel    = sel;
        line_in    = lvl;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic send_frame(input logic [7:0] d, input int nd, input bit hc, input logic c,
                              input int ns, input logic stop_last, output int t0);
        hold(1'b1, 20);
        t0 = tick_count;
        hold(1'b0, 16);
        for (int i = 0; i < nd; i++) hold(d[i], 16);
        if (hc) hold(c, 16);
        for (int s = 0; s < ns; s++) hold((s == ns - 1) ? stop_last : 1'b1, 16);
        hold(1'b1, 8);
    endtask

    task automatic test_reset();
        do_reset(1'b0, 2'b00, 1'b1);
        check_eq("R1 data_out after reset", data_out, 0);
        check_eq("R1 ctl_bit after reset", ctl_bit, 0);
        check_eq("R1 strobes after reset", {data_valid, frame_err, break_det, idle_det}, 0);
        hold(1'b1, 40);
        check_eq("R1 no frame strobes on high line", n_valid + n_ferr + n_brk, 0);
    endtask

    task automatic test_idle(input logic fl, input int limit);
        int i0;
        do_reset(fl, 2'b00, 1'b1);
        i0 = n_idle;
        hold(1'b1, limit - 2);
        check_eq("R11 idle not yet", n_idle - i0, 0);
        hold(1'b1, 4);
        check_eq("R11 idle at frame length", n_idle - i0, 1);
        hold(1'b1, 200);
        check_eq("R11 idle only once", n_idle - i0, 1);
    endtask

    task automatic test_frame(input string tag, input logic fl, input logic [1:0] sel,
                              input logic [7:0] d, input int nd, input bit hc, input logic c,
                              input int ns);
        int v0, f0, t0;
        logic [7:0] exp_d;
        do_reset(fl, sel, 1'b1);
        v0 = n_valid; f0 = n_ferr;
        send_frame(d, nd, hc, c, ns, 1'b1, t0);
        exp_d = (nd == 8) ? d : (d & 8'h7F);
        check_eq({tag, " valid count"}, n_valid - v0, 1);
        check_eq({tag, " no frame error"}, n_ferr - f0, 0);
        check_eq({tag, " R5 data word"}, lat_data, exp_d);
        check_eq({tag, " R5 control bit"}, lat_ctl, hc ? c : 1'b0);
        check_eq({tag, " R8 valid tick"}, lat_tick, t0 + 16 * (nd + (hc ? 1 : 0) + ns) + 10);
    endtask

    task automatic test_vote();
        int v0;
        logic [7:0] d = 8'h96;
        do_reset(1'b0, 2'b00, 1'b1);
        v0 = n_valid;
        hold(1'b1, 20);
        for (int b = 0; b < 10; b++) begin
            logic v;
            v = (b == 0) ? 1'b0 : ((b == 9) ? 1'b1 : d[b-1]);
            for (int j = 1; j <= 16; j++) begin
                line_in = (j == 8 + (b % 3) || j == 4 || j == 13) ? ~v : v;
                tick();
            end
        end
        hold(1'b1, 8);
        check_eq("R4 vote frame received", n_valid - v0, 1);
        check_eq("R4 vote data", lat_data, 8'h96);
    endtask

    task automatic test_false_start();
        int v0, f0, i0, t0;
        do_reset(1'b0, 2'b00, 1'b1);
        hold(1'b1, 20);
        v0 = n_valid; f0 = n_ferr; i0 = n_idle;
        hold(1'b0, 5);
        hold(1'b1, 200);
        check_eq("R3 false start no valid", n_valid - v0, 0);
        check_eq("R3 false start no error", n_ferr - f0, 0);
        check_eq("R3 back to waiting (idle seen)", n_idle - i0, 1);
        send_frame(8'h3C, 8, 1'b0, 1'b0, 1, 1'b1, t0);
        check_eq("R3 next frame valid", n_valid - v0, 1);
        check_eq("R3 next frame data", lat_data, 8'h3C);
    endtask

    task automatic test_qual(input int n_ones);
        int v0;
        do_reset(1'b0, 2'b00, 1'b0);
        hold(1'b0, 30);
        v0 = n_valid;
        hold(1'b1, n_ones);
        hold(1'b0, 16);
        hold(1'b1, 200);
        if (n_ones >= 3) begin
            check_eq("R2 start after 3 high ticks", n_valid - v0, 1);
            check_eq("R2 all-ones data", lat_data, 8'hFF);
        end else begin
            check_eq("R2 edge after 2 high ticks ignored", n_valid - v0, 0);
        end
    endtask

    task automatic test_ferr(input string tag, input logic [1:0] sel, input logic [7:0] d,
                             input int nd, input int ns);
        int v0, f0, b0, t0;
        do_reset(1'b0, sel, 1'b1);
        v0 = n_valid; f0 = n_ferr; b0 = n_brk;
        send_frame(d, nd, 1'b0, 1'b0, ns, 1'b0, t0);
        check_eq({tag, " R9 frame error"}, n_ferr - f0, 1);
        check_eq({tag, " R9 no valid"}, n_valid - v0, 0);
        check_eq({tag, " R9 data loaded"}, data_out, d);
        check_eq({tag, " R10 no break with ones"}, n_brk - b0, 0);
    endtask

    task automatic test_break();
        int v0, f0, b0;
        do_reset(1'b0, 2'b00, 1'b1);
        hold(1'b1, 20);
        v0 = n_valid; f0 = n_ferr; b0 = n_brk;
        hold(1'b0, 160);
        hold(1'b0, 8);
        check_eq("R10 break flagged", n_brk - b0, 1);
        check_eq("R10 break is a frame error", n_ferr - f0, 1);
        check_eq("R10 break no valid", n_valid - v0, 0);
        check_eq("R10 break data zero", data_out, 0);
        hold(1'b1, 40);
    endtask

    initial begin
        test_reset();
        test_idle(1'b0, 160);
        test_idle(1'b1, 176);
        test_frame("R6 8D1S", 1'b0, 2'b00, 8'hA5, 8, 1'b0, 1'b0, 1);
        test_frame("R6 7DC1S", 1'b0, 2'b01, 8'h5A, 7, 1'b1, 1'b1, 1);
        test_frame("R6 7D2S", 1'b0, 2'b10, 8'h33, 7, 1'b0, 1'b0, 2);
        test_frame("R6 7D2S alt", 1'b0, 2'b11, 8'h4E, 7, 1'b0, 1'b0, 2);
        test_frame("R7 8DC1S", 1'b1, 2'b00, 8'hC3, 8, 1'b1, 1'b1, 1);
        test_frame("R7 7DC2S", 1'b1, 2'b01, 8'h2B, 7, 1'b1, 1'b0, 2);
        test_frame("R7 sel1 ignored", 1'b1, 2'b10, 8'h81, 8, 1'b1, 1'b0, 1);
        test_vote();
        test_false_start();
        test_qual(2);
        test_qual(3);
        test_ferr("1 stop", 2'b00, 8'h55, 8, 1);
        test_ferr("2nd stop", 2'b10, 8'h33, 7, 2);
        test_break();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule